// File: doc/BRIEF.md
# Single-Cycle Datapath Steering Decoder

This block is the purely combinational steering logic of a single-cycle processor datapath that has an implicit stack pointer. It takes the decoded instruction class and function nibbles, the two register-name fields, the operand values read from the register file, the fetched constant, the sequential next address, the word loaded from data memory, the ALU result and the branch decision. From these it selects everything the surrounding datapath needs for one instruction in one cycle. Those selections are the register-file read and write port names, the ALU operands and operation, the flag-load strobe, the data-memory address, store data and access strobes, and the address of the next instruction.

The register file, ALU, memories, flag register and fetch unit sit outside the block. A register name of 8 on any port means "no access". The stack pointer is register 4. The block has no clock and no state: every output settles from the current inputs. Instruction classes use a fixed 4-bit code that the fetch unit also decodes:

| Code | Class | Code | Class |
|---|---|---|---|
| 0 | idle | 6 | arithmetic/logic |
| 1 | stop | 7 | conditional transfer |
| 2 | register copy | 8 | subroutine entry |
| 3 | constant load | 9 | subroutine exit |
| 4 | store | 10 | stack push |
| 5 | load | 11 | stack pop |

Codes 12 to 15 are undefined. The ALU operation code is 0 add, 1 subtract, 2 and, 3 exclusive-or.

Top module: `seqdp_ctrl`

## Requirements
- R1: Read port A names `fld_ra` for register copy, store, arithmetic/logic and push. It names 4 for pop and subroutine exit, and 8 otherwise.
- R2: Read port B names `fld_rb` for arithmetic/logic, store and load. It names 4 for push, pop, subroutine entry and exit, and 8 otherwise.
- R3: Write port E names `fld_rb` for register copy, constant load and arithmetic/logic. It names 4 for push, pop, subroutine entry and exit, and 8 otherwise.
- R4: Write port M names `fld_ra` for load and pop, and 8 otherwise. A pop therefore drives both write ports at once: the loaded word goes to `fld_ra` and the adjusted stack pointer goes to 4.
- R5: ALU input A is `rd_a` for register copy and arithmetic/logic. It is `imm_c` for constant load, store and load. It is -4 (32'hFFFFFFFC) for push and subroutine entry, +4 for pop and subroutine exit, and 0 otherwise.
- R6: ALU input B is 0 for register copy and constant load. It is `rd_b` for store, load, arithmetic/logic, push, pop, subroutine entry and exit, and 0 otherwise.
- R7: For the arithmetic/logic class, the ALU operation equals `ins_fn` and `cc_load` is 1. For every other code, the ALU operation is 0 (add) and `cc_load` is 0, whatever `ins_fn` holds.
- R8: The memory address is `rd_a` for pop and subroutine exit, and `alu_res` otherwise. The store data is `seq_pc` for subroutine entry and `rd_a` otherwise.
- R9: `dm_rd` is 1 only for load, pop and subroutine exit. `dm_wr` is 1 only for store, push and subroutine entry. The two are never 1 together.
- R10: The next address is `imm_c` for subroutine entry, `imm_c` for a conditional transfer with `br_taken`=1, `ld_data` for subroutine exit, and `seq_pc` otherwise. This includes a conditional transfer with `br_taken`=0.
- R11: Undefined codes 12 to 15 behave like idle: all four port names are 8, no flag load, no memory access, and the next address is `seq_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ins_cls | input | 4 | instruction class code |
| ins_fn | input | 4 | instruction function nibble |
| fld_ra | input | 4 | first register-name field |
| fld_rb | input | 4 | second register-name field |
| rd_a | input | W | value read on port A |
| rd_b | input | W | value read on port B |
| imm_c | input | W | fetched constant word |
| seq_pc | input | W | address of the following instruction |
| ld_data | input | W | word read from data memory |
| alu_res | input | W | ALU result |
| br_taken | input | 1 | branch condition is met |
| rs_sel_a | output | 4 | read port A register name |
| rs_sel_b | output | 4 | read port B register name |
| wr_sel_e | output | 4 | write port E register name (ALU result) |
| wr_sel_m | output | 4 | write port M register name (memory word) |
| alu_in_a | output | W | ALU operand A |
| alu_in_b | output | W | ALU operand B |
| alu_op | output | 4 | ALU operation code |
| cc_load | output | 1 | load the flag register |
| dm_addr | output | W | data-memory address |
| dm_wdata | output | W | data-memory store data |
| dm_rd | output | 1 | data-memory read strobe |
| dm_wr | output | 1 | data-memory write strobe |
| pc_next | output | W | next instruction address |

## Verification
The embedded assertions check cross-unit relations whenever the inputs change. Read and write strobes must never coincide. A write-port-M name must be backed by a memory read. The flag strobe must only appear with write port E aimed at `fld_rb`. The four stack classes must steer both read port B and write port E to register 4. A subroutine exit must take its next address from the loaded word. Only the bench's vectors can show the exact operand, address and next-address values for each class. They also show that a nonzero `ins_fn` outside the arithmetic class is ignored, that both branch outcomes are handled, and that undefined codes fall back to idle behaviour.

// File: rtl/seqdp_pkg.sv
package seqdp_pkg;

    localparam int RID_W = 4;
    localparam logic [RID_W-1:0] RID_SP   = 4'd4;
    localparam logic [RID_W-1:0] RID_NONE = 4'd8;

    typedef enum logic [3:0] {
        CLS_IDLE  = 4'h0,
        CLS_STOP  = 4'h1,
        CLS_RCOPY = 4'h2,
        CLS_KLOAD = 4'h3,
        CLS_STORE = 4'h4,
        CLS_LOAD  = 4'h5,
        CLS_ARITH = 4'h6,
        CLS_XFER  = 4'h7,
        CLS_ENTER = 4'h8,
        CLS_EXIT  = 4'h9,
        CLS_PUSH  = 4'hA,
        CLS_POP   = 4'hB
    } op_cls_e;

    localparam logic [3:0] ALU_ADD = 4'h0;

endpackage

// File: rtl/seqdp_regsel.sv
module seqdp_regsel
    import seqdp_pkg::*;
(
    input  logic [3:0]       ins_cls,
    input  logic [RID_W-1:0] fld_ra,
    input  logic [RID_W-1:0] fld_rb,
    output logic [RID_W-1:0] rs_sel_a,
    output logic [RID_W-1:0] rs_sel_b,
    output logic [RID_W-1:0] wr_sel_e,
    output logic [RID_W-1:0] wr_sel_m
);
    op_cls_e cls;
    assign cls = op_cls_e'(ins_cls);

    always_comb begin
        rs_sel_a = RID_NONE;
        rs_sel_b = RID_NONE;
        wr_sel_e = RID_NONE;
        wr_sel_m = RID_NONE;
        unique case (cls)
            CLS_RCOPY: begin
                rs_sel_a = fld_ra;
                wr_sel_e = fld_rb;
            end
            CLS_KLOAD: wr_sel_e = fld_rb;
            CLS_STORE: begin
                rs_sel_a = fld_ra;
                rs_sel_b = fld_rb;
            end
            CLS_LOAD: begin
                rs_sel_b = fld_rb;
                wr_sel_m = fld_ra;
            end
            CLS_ARITH: begin
                rs_sel_a = fld_ra;
                rs_sel_b = fld_rb;
                wr_sel_e = fld_rb;
            end
            CLS_ENTER: begin
                rs_sel_b = RID_SP;
                wr_sel_e = RID_SP;
            end
            CLS_EXIT: begin
                rs_sel_a = RID_SP;
                rs_sel_b = RID_SP;
                wr_sel_e = RID_SP;
            end
            CLS_PUSH: begin
                rs_sel_a = fld_ra;
                rs_sel_b = RID_SP;
                wr_sel_e = RID_SP;
            end
            CLS_POP: begin
                rs_sel_a = RID_SP;
                rs_sel_b = RID_SP;
                wr_sel_e = RID_SP;
                wr_sel_m = fld_ra;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/seqdp_alusel.sv
module seqdp_alusel
    import seqdp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   ins_cls,
    input  logic [3:0]   ins_fn,
    input  logic [W-1:0] rd_a,
    input  logic [W-1:0] rd_b,
    input  logic [W-1:0] imm_c,
    output logic [W-1:0] alu_in_a,
    output logic [W-1:0] alu_in_b,
    output logic [3:0]   alu_op,
    output logic         cc_load
);
    localparam logic [W-1:0] STEP_UP   = W'(4);
    localparam logic [W-1:0] STEP_DOWN = ~W'(3);

    op_cls_e cls;
    assign cls = op_cls_e'(ins_cls);

    always_comb begin
        alu_in_a = '0;
        alu_in_b = '0;
        alu_op   = ALU_ADD;
        cc_load  = 1'b0;
        unique case (cls)
            CLS_RCOPY: alu_in_a = rd_a;
            CLS_KLOAD: alu_in_a = imm_c;
            CLS_STORE, CLS_LOAD: begin
                alu_in_a = imm_c;
                alu_in_b = rd_b;
            end
            CLS_ARITH: begin
                alu_in_a = rd_a;
                alu_in_b = rd_b;
                alu_op   = ins_fn;
                cc_load  = 1'b1;
            end
            CLS_ENTER, CLS_PUSH: begin
                alu_in_a = STEP_DOWN;
                alu_in_b = rd_b;
            end
            CLS_EXIT, CLS_POP: begin
                alu_in_a = STEP_UP;
                alu_in_b = rd_b;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/seqdp_memsel.sv
module seqdp_memsel
    import seqdp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   ins_cls,
    input  logic [W-1:0] rd_a,
    input  logic [W-1:0] seq_pc,
    input  logic [W-1:0] alu_res,
    output logic [W-1:0] dm_addr,
    output logic [W-1:0] dm_wdata,
    output logic         dm_rd,
    output logic         dm_wr
);
    op_cls_e cls;
    assign cls = op_cls_e'(ins_cls);

    always_comb begin
        dm_addr  = alu_res;
        dm_wdata = rd_a;
        dm_rd    = 1'b0;
        dm_wr    = 1'b0;
        unique case (cls)
            CLS_STORE, CLS_PUSH: dm_wr = 1'b1;
            CLS_ENTER: begin
                dm_wr    = 1'b1;
                dm_wdata = seq_pc;
            end
            CLS_LOAD: dm_rd = 1'b1;
            CLS_EXIT, CLS_POP: begin
                dm_rd   = 1'b1;
                dm_addr = rd_a;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/seqdp_pcsel.sv
module seqdp_pcsel
    import seqdp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   ins_cls,
    input  logic         br_taken,
    input  logic [W-1:0] imm_c,
    input  logic [W-1:0] seq_pc,
    input  logic [W-1:0] ld_data,
    output logic [W-1:0] pc_next
);
    op_cls_e cls;
    assign cls = op_cls_e'(ins_cls);

    always_comb begin
        pc_next = seq_pc;
        unique case (cls)
            CLS_ENTER: pc_next = imm_c;
            CLS_XFER:  pc_next = br_taken ? imm_c : seq_pc;
            CLS_EXIT:  pc_next = ld_data;
            default: ;
        endcase
    end
endmodule

// File: rtl/seqdp_ctrl.sv
module seqdp_ctrl
    import seqdp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   ins_cls,
    input  logic [3:0]   ins_fn,
    input  logic [3:0]   fld_ra,
    input  logic [3:0]   fld_rb,
    input  logic [W-1:0] rd_a,
    input  logic [W-1:0] rd_b,
    input  logic [W-1:0] imm_c,
    input  logic [W-1:0] seq_pc,
    input  logic [W-1:0] ld_data,
    input  logic [W-1:0] alu_res,
    input  logic         br_taken,
    output logic [3:0]   rs_sel_a,
    output logic [3:0]   rs_sel_b,
    output logic [3:0]   wr_sel_e,
    output logic [3:0]   wr_sel_m,
    output logic [W-1:0] alu_in_a,
    output logic [W-1:0] alu_in_b,
    output logic [3:0]   alu_op,
    output logic         cc_load,
    output logic [W-1:0] dm_addr,
    output logic [W-1:0] dm_wdata,
    output logic         dm_rd,
    output logic         dm_wr,
    output logic [W-1:0] pc_next
);
    seqdp_regsel u_regsel (
        .ins_cls (ins_cls),
        .fld_ra  (fld_ra),
        .fld_rb  (fld_rb),
        .rs_sel_a(rs_sel_a),
        .rs_sel_b(rs_sel_b),
        .wr_sel_e(wr_sel_e),
        .wr_sel_m(wr_sel_m)
    );

    seqdp_alusel #(.W(W)) u_alusel (
        .ins_cls (ins_cls),
        .ins_fn  (ins_fn),
        .rd_a    (rd_a),
        .rd_b    (rd_b),
        .imm_c   (imm_c),
        .alu_in_a(alu_in_a),
        .alu_in_b(alu_in_b),
        .alu_op  (alu_op),
        .cc_load (cc_load)
    );

    seqdp_memsel #(.W(W)) u_memsel (
        .ins_cls (ins_cls),
        .rd_a    (rd_a),
        .seq_pc  (seq_pc),
        .alu_res (alu_res),
        .dm_addr (dm_addr),
        .dm_wdata(dm_wdata),
        .dm_rd   (dm_rd),
        .dm_wr   (dm_wr)
    );

    seqdp_pcsel #(.W(W)) u_pcsel (
        .ins_cls (ins_cls),
        .br_taken(br_taken),
        .imm_c   (imm_c),
        .seq_pc  (seq_pc),
        .ld_data (ld_data),
        .pc_next (pc_next)
    );

    // Cross-unit consistency checks between the four steering units.
    always_comb begin
        assert_rw_exclusive_R9: assert (!(dm_rd && dm_wr));
        if (wr_sel_m != RID_NONE) begin
            assert_portm_has_read_R4: assert (dm_rd);
        end
        if (cc_load) begin
            assert_cc_with_port_e_R7: assert (wr_sel_e == fld_rb);
        end
        if (ins_cls == CLS_PUSH || ins_cls == CLS_POP ||
            ins_cls == CLS_ENTER || ins_cls == CLS_EXIT) begin
            assert_stack_ports_R3: assert (wr_sel_e == RID_SP && rs_sel_b == RID_SP);
        end
        if (ins_cls == CLS_EXIT) begin
            assert_exit_uses_load_R10: assert (dm_rd && pc_next == ld_data);
        end
    end
endmodule

// File: tb/seqdp_ctrl_tb.sv
module seqdp_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    localparam logic [31:0] VA = 32'h0000_10A0;
    localparam logic [31:0] VB = 32'h0000_20B0;
    localparam logic [31:0] VC = 32'h0000_30C0;
    localparam logic [31:0] VP = 32'h0000_40D0;
    localparam logic [31:0] VM = 32'h0000_50E0;
    localparam logic [31:0] VE = 32'h0000_60F0;
    localparam logic [31:0] UP = 32'h0000_0004;
    localparam logic [31:0] DN = 32'hFFFF_FFFC;

    typedef struct packed {
        logic [3:0]  cls;
        logic [3:0]  fn;
        logic        br;
        logic [3:0]  sa;
        logic [3:0]  sb;
        logic [3:0]  de;
        logic [3:0]  dm;
        logic [31:0] aa;
        logic [31:0] ab;
        logic [3:0]  op;
        logic        cc;
        logic [31:0] ad;
        logic [31:0] wd;
        logic        rd;
        logic        wr;
        logic [31:0] pc;
    } vec_t;

    // register fields used by the table: fld_ra = 1, fld_rb = 2
    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{4'h0, 4'h0, 1'b0, 4'd8, 4'd8, 4'd8, 4'd8, 32'd0, 32'd0, 4'd0, 1'b0, VE, VA, 1'b0, 1'b0, VP},
        '{4'h1, 4'h0, 1'b0, 4'd8, 4'd8, 4'd8, 4'd8, 32'd0, 32'd0, 4'd0, 1'b0, VE, VA, 1'b0, 1'b0, VP},
        '{4'h2, 4'h0, 1'b0, 4'd1, 4'd8, 4'd2, 4'd8, VA,    32'd0, 4'd0, 1'b0, VE, VA, 1'b0, 1'b0, VP},
        '{4'h3, 4'h0, 1'b0, 4'd8, 4'd8, 4'd2, 4'd8, VC,    32'd0, 4'd0, 1'b0, VE, VA, 1'b0, 1'b0, VP},
        '{4'h4, 4'h0, 1'b0, 4'd1, 4'd2, 4'd8, 4'd8, VC,    VB,    4'd0, 1'b0, VE, VA, 1'b0, 1'b1, VP},
        '{4'h5, 4'h0, 1'b0, 4'd8, 4'd2, 4'd8, 4'd1, VC,    VB,    4'd0, 1'b0, VE, VA, 1'b1, 1'b0, VP},
        '{4'h6, 4'h1, 1'b0, 4'd1, 4'd2, 4'd2, 4'd8, VA,    VB,    4'd1, 1'b1, VE, VA, 1'b0, 1'b0, VP},
        '{4'h6, 4'h3, 1'b0, 4'd1, 4'd2, 4'd2, 4'd8, VA,    VB,    4'd3, 1'b1, VE, VA, 1'b0, 1'b0, VP},
        '{4'h7, 4'h3, 1'b1, 4'd8, 4'd8, 4'd8, 4'd8, 32'd0, 32'd0, 4'd0, 1'b0, VE, VA, 1'b0, 1'b0, VC},
        '{4'h7, 4'h3, 1'b0, 4'd8, 4'd8, 4'd8, 4'd8, 32'd0, 32'd0, 4'd0, 1'b0, VE, VA, 1'b0, 1'b0, VP},
        '{4'h8, 4'h0, 1'b0, 4'd8, 4'd4, 4'd4, 4'd8, DN,    VB,    4'd0, 1'b0, VE, VP, 1'b0, 1'b1, VC},
        '{4'h9, 4'h0, 1'b0, 4'd4, 4'd4, 4'd4, 4'd8, UP,    VB,    4'd0, 1'b0, VA, VA, 1'b1, 1'b0, VM},
        '{4'hA, 4'h0, 1'b0, 4'd1, 4'd4, 4'd4, 4'd8, DN,    VB,    4'd0, 1'b0, VE, VA, 1'b0, 1'b1, VP},
        '{4'hB, 4'h0, 1'b0, 4'd4, 4'd4, 4'd4, 4'd1, UP,    VB,    4'd0, 1'b0, VA, VA, 1'b1, 1'b0, VP},
        '{4'hC, 4'h0, 1'b1, 4'd8, 4'd8, 4'd8, 4'd8, 32'd0, 32'd0, 4'd0, 1'b0, VE, VA, 1'b0, 1'b0, VP},
        '{4'hF, 4'h6, 1'b1, 4'd8, 4'd8, 4'd8, 4'd8, 32'd0, 32'd0, 4'd0, 1'b0, VE, VA, 1'b0, 1'b0, VP},
        '{4'h2, 4'h2, 1'b1, 4'd1, 4'd8, 4'd2, 4'd8, VA,    32'd0, 4'd0, 1'b0, VE, VA, 1'b0, 1'b0, VP}
    };

    logic clk = 1'b0;
    logic [3:0]   ins_cls, ins_fn, fld_ra, fld_rb;
    logic [W-1:0] rd_a, rd_b, imm_c, seq_pc, ld_data, alu_res;
    logic         br_taken;
    logic [3:0]   rs_sel_a, rs_sel_b, wr_sel_e, wr_sel_m, alu_op;
    logic [W-1:0] alu_in_a, alu_in_b, dm_addr, dm_wdata, pc_next;
    logic         cc_load, dm_rd, dm_wr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seqdp_ctrl #(.W(W)) u_dut (
        .ins_cls(ins_cls), .ins_fn(ins_fn), .fld_ra(fld_ra), .fld_rb(fld_rb),
        .rd_a(rd_a), .rd_b(rd_b), .imm_c(imm_c), .seq_pc(seq_pc),
        .ld_data(ld_data), .alu_res(alu_res), .br_taken(br_taken),
        .rs_sel_a(rs_sel_a), .rs_sel_b(rs_sel_b), .wr_sel_e(wr_sel_e),
        .wr_sel_m(wr_sel_m), .alu_in_a(alu_in_a), .alu_in_b(alu_in_b),
        .alu_op(alu_op), .cc_load(cc_load), .dm_addr(dm_addr),
        .dm_wdata(dm_wdata), .dm_rd(dm_rd), .dm_wr(dm_wr), .pc_next(pc_next)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] c, input logic [3:0] f,
                         input logic [3:0] ra, input logic [3:0] rb, input logic b);
        @(posedge clk);
        ins_cls = c; ins_fn = f; fld_ra = ra; fld_rb = rb; br_taken = b;
        @(negedge clk);
    endtask

    initial begin
        ins_cls = '0; ins_fn = '0; fld_ra = '0; fld_rb = '0; br_taken = 1'b0;
        rd_a = VA; rd_b = VB; imm_c = VC; seq_pc = VP; ld_data = VM; alu_res = VE;
        @(negedge clk);
        // idle state on all-zero instruction fields (R11 baseline)
        chk("R11", "idle port A", {28'd0, rs_sel_a}, 32'd8);
        chk("R11", "idle next pc", pc_next, VP);
        chk("R9", "idle no access", {30'd0, dm_rd, dm_wr}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].cls, TBL[i].fn, 4'd1, 4'd2, TBL[i].br);
            chk("R1",  "port A",  {28'd0, rs_sel_a}, {28'd0, TBL[i].sa});
            chk("R2",  "port B",  {28'd0, rs_sel_b}, {28'd0, TBL[i].sb});
            chk("R3",  "port E",  {28'd0, wr_sel_e}, {28'd0, TBL[i].de});
            chk("R4",  "port M",  {28'd0, wr_sel_m}, {28'd0, TBL[i].dm});
            chk("R5",  "alu A",   alu_in_a, TBL[i].aa);
            chk("R6",  "alu B",   alu_in_b, TBL[i].ab);
            chk("R7",  "alu op",  {28'd0, alu_op}, {28'd0, TBL[i].op});
            chk("R7",  "cc load", {31'd0, cc_load}, {31'd0, TBL[i].cc});
            chk("R8",  "address", dm_addr, TBL[i].ad);
            chk("R8",  "wdata",   dm_wdata, TBL[i].wd);
            chk("R9",  "rd/wr",   {30'd0, dm_rd, dm_wr}, {30'd0, TBL[i].rd, TBL[i].wr});
            chk("R10", "next pc", pc_next, TBL[i].pc);
            if (TBL[i].cls >= 4'hC) begin
                chk("R11", "undefined idle", {28'd0, wr_sel_e}, 32'd8);
            end
        end

        // pop with distinct fields: both write ports active, different names
        drive(4'hB, 4'h0, 4'd7, 4'd3, 1'b0);
        chk("R4", "pop port M", {28'd0, wr_sel_m}, 32'd7);
        chk("R3", "pop port E", {28'd0, wr_sel_e}, 32'd4);
        chk("R2", "pop ignores rb", {28'd0, rs_sel_b}, 32'd4);

        // arithmetic with other fields and function 2
        drive(4'h6, 4'h2, 4'd5, 4'd6, 1'b1);
        chk("R1", "arith port A", {28'd0, rs_sel_a}, 32'd5);
        chk("R3", "arith port E", {28'd0, wr_sel_e}, 32'd6);
        chk("R7", "arith op and", {28'd0, alu_op}, 32'd2);
        chk("R10", "arith ignores branch", pc_next, VP);

        // subroutine entry ignores branch flag, fresh data values
        seq_pc = 32'h1234_5678; imm_c = 32'h0000_0ABC;
        drive(4'h8, 4'h5, 4'd0, 4'd0, 1'b0);
        chk("R10", "entry target", pc_next, 32'h0000_0ABC);
        chk("R8", "entry wdata", dm_wdata, 32'h1234_5678);
        chk("R7", "entry fn ignored", {28'd0, alu_op}, 32'd0);

        // exit uses loaded word, address from port A value
        ld_data = 32'hCAFE_0010; rd_a = 32'h0000_0F00;
        drive(4'h9, 4'h0, 4'd0, 4'd0, 1'b1);
        chk("R10", "exit target", pc_next, 32'hCAFE_0010);
        chk("R8", "exit address", dm_addr, 32'h0000_0F00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule